// File: doc/BRIEF.md
# Reconfigurable Logic Cell

This block models one element of a programmable logic fabric. A single 16-entry, 1-bit cell array is shared by three run-time modes. It can be a 4-input truth table, a 16x1 RAM with a synchronous write, or a 16-bit shift register with a selectable tap. The four select inputs always choose the array entry that is read. The cell output is either that entry, taken straight out, or the entry after it passes through a storage element. The storage element can be an edge-triggered flop on either clock edge or a transparent latch. It has a clock enable and an asynchronous clear whose active level is set by configuration.

All setup bits form one serial chain: six control bits followed by the sixteen array bits. The chain is loaded one bit per rising clock edge while the load enable is high. During loading, array writes, shifts and storage captures are suspended. A surrounding fabric model instantiates one cell per site and loads each chain in turn.

Top module: `cfg_logic_cell`

## Requirements
- R1: A synchronous active-high `rst` clears all control bits, the whole array and the storage element. After it, the cell is in truth-table mode with a direct output, and `y` is 0 for every `sel`.
- R2: While `cfg_en` is high, each rising edge shifts `cfg_din` into the chain. After 22 edges the first bit sent sits in control bit 5. The control bits are [5:4] mode, [3] registered output, [2] latch select, [1] falling-edge select and [0] active-low clear. The last 16 bits sent land in array entries 15 down to 0, so the last bit sent is entry 0.
- R3: In mode 00 (truth table), with a direct output, `y` equals array entry `sel` in the same cycle. `wr_en` has no effect on the array.
- R4: In mode 01 (RAM), a rising edge with `wr_en` high writes `wr_bit` into entry `sel`. Reads are combinational.
- R5: In mode 10 (shift register), a rising edge with `wr_en` high moves entry i to entry i+1 and loads `wr_bit` into entry 0. `y` shows entry `sel`. With `wr_en` low, the array holds.
- R6: While `cfg_en` is high, `wr_en` neither writes nor shifts, and the storage element does not capture.
- R7: With a registered output, flop mode and rising-edge select, the storage element takes the looked-up bit on the rising edge. It does not change at the falling edge.
- R8: With the falling-edge select set, the storage element captures only on the falling clock edge.
- R9: With `st_ce` low, the storage element keeps its value across clock edges.
- R10: In latch mode, `y` follows the looked-up bit while `st_ce` is high. It holds while `st_ce` is low.
- R11: `st_clr` clears the storage element at once, with no clock edge needed. It acts when high if control bit 0 is 0, and when low if control bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Serial configuration load enable |
| cfg_din | input | 1 | Serial configuration bit |
| sel | input | 4 | Array entry select: truth-table input, RAM address or shift tap |
| wr_en | input | 1 | RAM write / shift enable |
| wr_bit | input | 1 | RAM write data / shift-in bit |
| st_ce | input | 1 | Storage element clock (or latch) enable |
| st_clr | input | 1 | Storage element asynchronous clear, polarity set by configuration |
| y | output | 1 | Cell output |

## Verification
A direct output is a pure lookup of the current array, so the bench samples it 1 ns after changing `sel`. RAM writes and shifts show up right after the first rising edge that samples `wr_en`. A rising-edge flop updates at that same edge. A falling-edge flop updates half a period later, and the bench checks both before and after that falling edge. The latch and the asynchronous clear act with no edge at all. The bench drives every input 1 ns after a rising edge and checks inside the same half-cycle for these. The serial chain takes exactly 22 edges, and the array contents are then read back through `y` to prove the bit order.

// File: rtl/cle_pkg.sv
package cle_pkg;

  typedef enum logic [1:0] {
    MODE_LUT   = 2'b00,
    MODE_RAM   = 2'b01,
    MODE_SHIFT = 2'b10,
    MODE_SPARE = 2'b11
  } cle_mode_e;

  // Field order is the serial chain order: first bit sent ends in mode[1].
  typedef struct packed {
    cle_mode_e mode;
    logic      out_reg;
    logic      latch_mode;
    logic      fall_edge;
    logic      clr_low;
  } cle_ctrl_t;

  localparam int CTRL_W = $bits(cle_ctrl_t);

endpackage

// File: rtl/cle_ctrl_reg.sv
module cle_ctrl_reg
  import cle_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cfg_en,
  input  logic      chain_i,
  output cle_ctrl_t ctrl
);

  logic [CTRL_W-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
    end else if (cfg_en) begin
      bits_q <= {bits_q[CTRL_W-2:0], chain_i};
    end
  end

  assign ctrl = cle_ctrl_t'(bits_q);

  // R2: the chain bit from the array enters control bit 0 on each load edge
  a_r2_ctrl_shift_in: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !rst) |=> (bits_q[0] == $past(chain_i)));

  // R6 (control side): outside loading the control word is frozen
  a_r6_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !rst) |=> $stable(bits_q));

endmodule

// File: rtl/cle_cell_array.sv
module cle_cell_array
  import cle_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_en,
  input  logic                     cfg_din,
  input  cle_mode_e                mode,
  input  logic [$clog2(DEPTH)-1:0] sel,
  input  logic                     wr_en,
  input  logic                     wr_bit,
  output logic                     rd_bit,
  output logic                     chain_o
);

  logic [DEPTH-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
    end else if (cfg_en) begin
      mem_q <= {mem_q[DEPTH-2:0], cfg_din};
    end else if (wr_en) begin
      case (mode)
        MODE_RAM:   mem_q[sel] <= wr_bit;
        MODE_SHIFT: mem_q <= {mem_q[DEPTH-2:0], wr_bit};
        default:    ;
      endcase
    end
  end

  assign rd_bit  = mem_q[sel];
  assign chain_o = mem_q[DEPTH-1];

  // R3: truth-table (and spare) mode leaves the array untouched
  a_r3_lut_static: assert property (@(posedge clk) disable iff (rst)
    (!rst && !cfg_en && mode != MODE_RAM && mode != MODE_SHIFT) |=> $stable(mem_q));

  // R4: a RAM write lands at the addressed entry
  a_r4_ram_write: assert property (@(posedge clk) disable iff (rst)
    (!rst && !cfg_en && mode == MODE_RAM && wr_en) |=> (mem_q[$past(sel)] == $past(wr_bit)));

  // R5: an idle shift register holds
  a_r5_shift_idle: assert property (@(posedge clk) disable iff (rst)
    (!rst && !cfg_en && mode == MODE_SHIFT && !wr_en) |=> $stable(mem_q));

  // R6: during loading the array takes the serial bit, never the write data
  a_r6_load_only: assert property (@(posedge clk) disable iff (rst)
    (!rst && cfg_en) |=> (mem_q[0] == $past(cfg_din)));

endmodule

// File: rtl/cle_storage.sv
module cle_storage (
  input  logic clk,
  input  logic rst,
  input  logic frz,
  input  logic d,
  input  logic ce,
  input  logic sr,
  input  logic latch_mode,
  input  logic fall_edge,
  input  logic clr_low,
  output logic q
);

  logic clr;
  logic en;
  logic q_rise;
  logic q_fall;
  logic q_lat;

  assign clr = rst | (sr ^ clr_low);
  assign en  = ce & ~frz;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)     q_rise <= 1'b0;
    else if (en) q_rise <= d;
  end

  always_ff @(negedge clk or posedge clr) begin
    if (clr)     q_fall <= 1'b0;
    else if (en) q_fall <= d;
  end

  always_latch begin
    if (clr)     q_lat <= 1'b0;
    else if (en) q_lat <= d;
  end

  assign q = latch_mode ? q_lat : (fall_edge ? q_fall : q_rise);

  // R7: an enabled rising-edge flop holds the bit seen at the edge
  a_r7_rise_capture: assert property (@(posedge clk) disable iff (clr)
    en |=> (q_rise == $past(d)));

  // R9: with the enable low the rising flop keeps its value
  a_r9_rise_hold: assert property (@(posedge clk) disable iff (clr)
    !en |=> $stable(q_rise));

  // R9: same for the falling-edge copy
  a_r9_fall_hold: assert property (@(negedge clk) disable iff (clr)
    !en |=> $stable(q_fall));

  // R11: while the clear is active every copy reads zero
  a_r11_clear_zero: assert property (@(posedge clk)
    clr |-> (q_rise == 1'b0 && q_fall == 1'b0 && q_lat == 1'b0));

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import cle_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_en,
  input  logic                     cfg_din,
  input  logic [$clog2(DEPTH)-1:0] sel,
  input  logic                     wr_en,
  input  logic                     wr_bit,
  input  logic                     st_ce,
  input  logic                     st_clr,
  output logic                     y
);

  cle_ctrl_t ctrl;
  logic      chain;
  logic      lut_bit;
  logic      st_q;

  cle_cell_array #(.DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .rst     (rst),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .mode    (ctrl.mode),
    .sel     (sel),
    .wr_en   (wr_en),
    .wr_bit  (wr_bit),
    .rd_bit  (lut_bit),
    .chain_o (chain)
  );

  cle_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cfg_en  (cfg_en),
    .chain_i (chain),
    .ctrl    (ctrl)
  );

  cle_storage u_store (
    .clk        (clk),
    .rst        (rst),
    .frz        (cfg_en),
    .d          (lut_bit),
    .ce         (st_ce),
    .sr         (st_clr),
    .latch_mode (ctrl.latch_mode),
    .fall_edge  (ctrl.fall_edge),
    .clr_low    (ctrl.clr_low),
    .q          (st_q)
  );

  assign y = ctrl.out_reg ? st_q : lut_bit;

  // R3: a direct output always shows the selected entry
  a_r3_direct_out: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.out_reg) |-> (y == lut_bit));

endmodule

// File: tb/cfg_logic_cell_test.sv
`timescale 1ns/1ps
module cfg_logic_cell_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b0;
  logic       cfg_din = 1'b0;
  logic [3:0] sel = '0;
  logic       wr_en = 1'b0;
  logic       wr_bit = 1'b0;
  logic       st_ce = 1'b0;
  logic       st_clr = 1'b0;
  logic       y;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;   // 125 MHz

  cfg_logic_cell uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .sel(sel),
    .wr_en(wr_en), .wr_bit(wr_bit), .st_ce(st_ce), .st_clr(st_clr), .y(y)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endtask

  function automatic logic [21:0] mk(input logic [1:0] m, input logic o_reg,
      input logic lat, input logic fal, input logic low, input logic [15:0] t);
    return {m, o_reg, lat, fal, low, t};
  endfunction

  task automatic load_cfg(input logic [21:0] v);
    @(posedge clk); #1;
    cfg_en = 1'b1;
    for (int i = 21; i >= 0; i--) begin
      cfg_din = v[i];
      @(posedge clk); #1;
    end
    cfg_en = 1'b0;
  endtask

  task automatic check_all(input string req, input logic [15:0] exp);
    for (int i = 0; i < 16; i++) begin
      sel = 4'(i);
      #1;
      chk(req, y, exp[i]);
    end
  endtask

  task automatic t_reset();
    check_all("R1 reset", 16'h0000);
  endtask

  task automatic t_lut();
    load_cfg(mk(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3));
    check_all("R2 chain order", 16'hA5C3);
    sel = 4'd2; wr_bit = 1'b1; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    check_all("R3 wr_en ignored", 16'hA5C3);
  endtask

  task automatic t_ram();
    logic [15:0] m = '0;
    load_cfg(mk(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000));
    for (int i = 0; i < 16; i++) begin
      sel = 4'(i); wr_bit = (i % 3 == 0); wr_en = 1'b1;
      m[i] = (i % 3 == 0);
      @(posedge clk); #1;
    end
    wr_en = 1'b0;
    check_all("R4 ram write", m);
    sel = 4'd5; wr_bit = 1'b1; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; m[5] = 1'b1;
    check_all("R4 ram rewrite", m);
  endtask

  task automatic t_shift();
    logic [9:0]  pat = 10'b1011001110;
    logic [15:0] m = 16'h00F0;
    load_cfg(mk(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00F0));
    for (int i = 9; i >= 0; i--) begin
      wr_bit = pat[i]; wr_en = 1'b1;
      m = {m[14:0], pat[i]};
      @(posedge clk); #1;
    end
    wr_en = 1'b0;
    check_all("R5 shift taps", m);
    wr_bit = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check_all("R5 shift hold", m);
  endtask

  task automatic t_freeze();
    sel = 4'd7; wr_bit = 1'b1; wr_en = 1'b1;
    load_cfg(mk(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 16'h5A3C));
    wr_en = 1'b0;
    check_all("R6 no write during load", 16'h5A3C);
  endtask

  task automatic t_rise();
    st_ce = 1'b1; sel = 4'd12;
    load_cfg(mk(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 16'h00FF));
    st_clr = 1'b1; #1;
    chk("R11 clear active high", y, 1'b0);
    st_clr = 1'b0; sel = 4'd3;
    #3;
    chk("R7 no capture on fall", y, 1'b0);
    @(posedge clk); #1;
    chk("R7 capture on rise", y, 1'b1);
    st_ce = 1'b0; sel = 4'd12;
    @(posedge clk); #1;
    chk("R9 enable low holds", y, 1'b1);
    st_ce = 1'b1;
    @(posedge clk); #1;
    chk("R7 capture zero", y, 1'b0);
  endtask

  task automatic t_fall();
    load_cfg(mk(2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 16'h00FF));
    st_clr = 1'b1; #1; st_clr = 1'b0;
    sel = 4'd3; #1;
    chk("R8 before falling edge", y, 1'b0);
    @(negedge clk); #1;
    chk("R8 falling capture", y, 1'b1);
    @(posedge clk); #1;
    sel = 4'd12; #2;
    chk("R8 rising edge ignored", y, 1'b1);
    #2;
    chk("R8 falling capture zero", y, 1'b0);
  endtask

  task automatic t_latch();
    load_cfg(mk(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 16'h00FF));
    st_ce = 1'b1; sel = 4'd3; #1;
    chk("R10 transparent high", y, 1'b1);
    sel = 4'd12; #1;
    chk("R10 transparent low", y, 1'b0);
    sel = 4'd3; #1;
    st_ce = 1'b0; #1;
    sel = 4'd12; #1;
    chk("R10 latch holds", y, 1'b1);
    @(posedge clk); #1;
    chk("R10 holds over edge", y, 1'b1);
  endtask

  task automatic t_clr_low();
    st_clr = 1'b1;
    load_cfg(mk(2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 16'h00FF));
    st_ce = 1'b1; sel = 4'd3; #1;
    chk("R11 high level idle when active low", y, 1'b1);
    st_ce = 1'b0; #1;
    st_clr = 1'b0; #1;
    chk("R11 active low clear", y, 1'b0);
    st_clr = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_lut();
    t_ram();
    t_shift();
    t_freeze();
    t_rise();
    t_fall();
    t_latch();
    t_clr_low();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule